// File: doc/BRIEF.md
# Single-Wire Slave Network Addressing Layer

This block is the network-command layer of a slave on a single-wire, open-drain bus. It sits above a timing engine that turns the line into discrete events: a bus reset (with a flag telling whether it was a long, standard-length reset) and one event per time slot carrying the sampled line level. After each bus reset the block collects an 8-bit network command, sent least significant bit first. Depending on that command it either transmits its 64-bit identity, compares a received identity against its own, or takes part in a bitwise search arbitration. It then decides whether the slave is selected for the memory-command layer that follows.

The identity is built from parameters. A family code sits in bits 7:0 and a 48-bit serial in bits 55:8. Bits 63:56 hold a CRC-8 over the lower 56 bits, computed at elaboration. Two sticky flags live here. The resume flag lets a later resume command re-select a slave that was the last one addressed. The overdrive flag tells the timing engine to use fast slot timing. When the slave has a bit to send in the coming slot, it requests the line to be held low through `drive_low_o`; a '1' is sent by leaving the line released.

Top module: `swnet_addr_layer`

## Requirements
- R1: After `rst_n` is released the block is deselected, overdrive is 0 and the line is released. Slot events are ignored until the first bus reset.
- R2: A bus reset at any moment abandons the current command. From the next cycle the slave is deselected, the line is released and a new 8-bit command is collected.
- R3: Command 33h transmits the 64-bit identity over 64 slots, bit 0 first. Bits 7:0 are the family code, bits 55:8 the serial, and bits 63:56 the CRC-8 (polynomial x^8+x^5+x^4+1, zero start, data fed LSB first). The slave is selected after the 64th slot.
- R4: Command 55h compares 64 received bits with the identity, bit 0 first. A full match selects the slave. The first differing bit leaves it deselected until the next bus reset, whatever bits follow.
- R5: Command F0h runs a search for each identity bit, bit 0 first, in three slots. The slave sends the bit, then its complement, then reads the master's choice. A choice that differs drops the slave out until the next bus reset, with the line released. Completing all 64 bits selects it.
- R6: Command CCh selects the slave right after the command byte.
- R7: A completed match, search or overdrive-match sets the resume flag. Commands 33h, 55h, F0h, CCh, 3Ch and 69h clear it when their byte completes. Command A5h selects the slave only if the flag is set and does not change it.
- R8: Command 3Ch sets overdrive to 1 and selects the slave.
- R9: Command 69h sets overdrive to 1 as soon as its byte completes, then behaves like 55h. On a mismatch overdrive returns to the value it had before the command.
- R10: Any other command byte leaves the slave deselected until the next bus reset, with the resume and overdrive flags unchanged.
- R11: A bus reset flagged as long clears overdrive. A short bus reset keeps it.
- R12: In slots where the slave receives, or while it is deselected, `drive_low_o` is 0. In slots where it sends, `drive_low_o` is the inverse of the bit being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: timing engine saw a bus reset |
| reset_slow_i | input | 1 | Qualifies `bus_reset_i`: reset was standard length |
| bit_valid_i | input | 1 | One-cycle pulse: a time slot completed |
| bit_i | input | 1 | Line level sampled in that slot |
| drive_low_o | output | 1 | Hold the line low in the next slot (sends a 0) |
| selected_o | output | 1 | Slave is addressed; memory layer may run |
| overdrive_o | output | 1 | Fast slot timing in effect |

## Verification
The bench builds the block with the default family code 23h and overrides the serial with 5EA107C3924Bh. That serial has both bit values spread over all six bytes, so a single flipped bit at positions 5, 10 or 40 produces a real mismatch. The bench computes the identity and its CRC independently and uses them to drive full 64-bit match, search and overdrive-match passes. It also confirms that the CRC residual over the transmitted 64 bits is zero. Chains of short and long bus resets between commands carry the resume and overdrive flags from one command to the next. This covers both fall-back outcomes of a failed overdrive-match: overdrive was off before the command, or it was already on.

// File: rtl/swnet_pkg.sv
`timescale 1ns/1ps
package swnet_pkg;

    localparam int FAM_W  = 8;
    localparam int SER_W  = 48;
    localparam int CRC_W  = 8;
    localparam int BODY_W = FAM_W + SER_W;
    localparam int ID_W   = BODY_W + CRC_W;
    localparam int IDX_W  = $clog2(ID_W);
    localparam int CMD_W  = 8;
    localparam int BCNT_W = $clog2(CMD_W);

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    localparam logic [CMD_W-1:0] OP_READ_ID   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH     = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH    = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP      = 8'hCC;
    localparam logic [CMD_W-1:0] OP_RESUME    = 8'hA5;
    localparam logic [CMD_W-1:0] OP_FAST_SKIP = 8'h3C;
    localparam logic [CMD_W-1:0] OP_FAST_MTCH = 8'h69;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_SENDID = 3'd2,
        ST_MATCH  = 3'd3,
        ST_SEARCH = 3'd4,
        ST_SEL    = 3'd5
    } net_st_e;

    localparam logic [1:0] PH_TRUE = 2'd0;
    localparam logic [1:0] PH_COMP = 2'd1;
    localparam logic [1:0] PH_PICK = 2'd2;

    typedef struct packed {
        net_st_e            st;
        logic [IDX_W-1:0]   idx;
        logic [1:0]         ph;
        logic [CMD_W-1:0]   sh;
        logic [BCNT_W-1:0]  bcnt;
        logic               rc;
        logic               od;
        logic               od_prev;
    } net_s;

    function automatic logic [CRC_W-1:0] crc8_lsb(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = 0; i < BODY_W; i++) begin
            fb = c[0] ^ body[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/swnet_id_store.sv
`timescale 1ns/1ps
module swnet_id_store
    import swnet_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY = 8'h23,
    parameter logic [SER_W-1:0] SERIAL = 48'h0000_0000_0001
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             id_bit_o
);
    localparam logic [BODY_W-1:0] BODY = {SERIAL, FAMILY};
    localparam logic [ID_W-1:0]   ID   = {crc8_lsb(BODY), BODY};

    assign id_bit_o = ID[idx_i];
endmodule

// File: rtl/swnet_cmd_decode.sv
`timescale 1ns/1ps
module swnet_cmd_decode
    import swnet_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             rc_i,
    input  logic             od_i,
    output net_st_e          st_o,
    output logic             rc_o,
    output logic             od_o
);
    always_comb begin
        st_o = ST_IDLE;
        rc_o = 1'b0;
        od_o = od_i;
        case (cmd_i)
            OP_READ_ID:   st_o = ST_SENDID;
            OP_MATCH:     st_o = ST_MATCH;
            OP_SEARCH:    st_o = ST_SEARCH;
            OP_SKIP:      st_o = ST_SEL;
            OP_RESUME: begin
                rc_o = rc_i;
                st_o = rc_i ? ST_SEL : ST_IDLE;
            end
            OP_FAST_SKIP: begin
                od_o = 1'b1;
                st_o = ST_SEL;
            end
            OP_FAST_MTCH: begin
                od_o = 1'b1;
                st_o = ST_MATCH;
            end
            default: begin
                rc_o = rc_i;
                st_o = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/swnet_addr_layer.sv
`timescale 1ns/1ps
module swnet_addr_layer
    import swnet_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY = 8'h23,
    parameter logic [SER_W-1:0] SERIAL = 48'h0000_0000_0001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset_i,
    input  logic reset_slow_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic drive_low_o,
    output logic selected_o,
    output logic overdrive_o
);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(ID_W - 1);
    localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(CMD_W - 1);

    net_s             q, d;
    net_st_e          dec_st;
    logic             dec_rc, dec_od, id_bit;
    logic [CMD_W-1:0] cmd_byte;

    assign cmd_byte = {bit_i, q.sh[CMD_W-1:1]};

    swnet_id_store #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
        .idx_i    (q.idx),
        .id_bit_o (id_bit)
    );

    swnet_cmd_decode u_dec (
        .cmd_i (cmd_byte),
        .rc_i  (q.rc),
        .od_i  (q.od),
        .st_o  (dec_st),
        .rc_o  (dec_rc),
        .od_o  (dec_od)
    );

    always_comb begin
        d = q;
        if (bus_reset_i) begin
            d.st   = ST_CMD;
            d.bcnt = '0;
            d.idx  = '0;
            d.ph   = PH_TRUE;
            if (reset_slow_i) d.od = 1'b0;
        end else if (bit_valid_i) begin
            case (q.st)
                ST_CMD: begin
                    d.sh   = cmd_byte;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == BCNT_LAST) begin
                        d.st      = dec_st;
                        d.rc      = dec_rc;
                        d.od      = dec_od;
                        d.od_prev = q.od;
                        d.idx     = '0;
                        d.ph      = PH_TRUE;
                    end
                end
                ST_SENDID: begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDX_LAST) d.st = ST_SEL;
                end
                ST_MATCH: begin
                    if (bit_i != id_bit) begin
                        d.st = ST_IDLE;
                        d.od = q.od_prev;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        if (q.idx == IDX_LAST) begin
                            d.st = ST_SEL;
                            d.rc = 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (q.ph == PH_TRUE) begin
                        d.ph = PH_COMP;
                    end else if (q.ph == PH_COMP) begin
                        d.ph = PH_PICK;
                    end else if (bit_i != id_bit) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.ph  = PH_TRUE;
                        d.idx = q.idx + 1'b1;
                        if (q.idx == IDX_LAST) begin
                            d.st = ST_SEL;
                            d.rc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign selected_o  = (q.st == ST_SEL);
    assign overdrive_o = q.od;
    assign drive_low_o = ((q.st == ST_SENDID) && !id_bit) ||
                         ((q.st == ST_SEARCH) && (q.ph == PH_TRUE) && !id_bit) ||
                         ((q.st == ST_SEARCH) && (q.ph == PH_COMP) &&  id_bit);

    AST_RESET_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !selected_o); // R2
    AST_RESET_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !drive_low_o); // R2
    AST_LONG_RESET_CLEARS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && reset_slow_i) |=> !overdrive_o); // R11
    AST_SELECTION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (selected_o && !bus_reset_i) |=> selected_o); // R6
    AST_SELECT_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> $past(bit_valid_i)); // R7
    AST_FAST_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdrive_o) |-> $past(bit_valid_i)); // R8
    AST_FAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid_i && !bus_reset_i) |=> $stable(overdrive_o)); // R9
    AST_NO_DRIVE_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        selected_o |-> !drive_low_o); // R12
endmodule

// File: tb/swnet_addr_layer_test.sv
`timescale 1ns/1ps
module swnet_addr_layer_test;

    localparam logic [7:0]  FAM = 8'h23;
    localparam logic [47:0] SER = 48'h5EA1_07C3_924B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0, reset_slow_i = 1'b0;
    logic bit_valid_i = 1'b0, bit_i = 1'b0;
    logic drive_low_o, selected_o, overdrive_o;

    int n_chk = 0, n_fail = 0, rx_drive_err = 0;
    bit done = 1'b0;
    logic [63:0] exp_id;

    always #10 clk = ~clk;

    swnet_addr_layer #(.FAMILY(FAM), .SERIAL(SER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .reset_slow_i(reset_slow_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i), .drive_low_o(drive_low_o),
        .selected_o(selected_o), .overdrive_o(overdrive_o)
    );

    // {long reset, command, expected selected, expected overdrive}
    localparam logic [10:0] VEC [0:8] = '{
        {1'b1, 8'hCC, 1'b1, 1'b0},  // R6
        {1'b1, 8'hA5, 1'b0, 1'b0},  // R7 flag cleared by skip
        {1'b0, 8'h3C, 1'b1, 1'b1},  // R8
        {1'b0, 8'hCC, 1'b1, 1'b1},  // R11 short reset keeps fast mode
        {1'b1, 8'hA5, 1'b0, 1'b0},  // R11 long reset clears it
        {1'b0, 8'h12, 1'b0, 1'b0},  // R10
        {1'b1, 8'h3C, 1'b1, 1'b1},  // R8
        {1'b0, 8'h77, 1'b0, 1'b1},  // R10 fast mode untouched
        {1'b1, 8'hCC, 1'b1, 1'b0}   // R6 R11
    };

    function automatic logic [7:0] ref_crc(input logic [55:0] body);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ body[i];
            c = {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_rst(input logic slow);
        @(negedge clk); bus_reset_i = 1'b1; reset_slow_i = slow;
        @(negedge clk); bus_reset_i = 1'b0; reset_slow_i = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk);
        if (drive_low_o) rx_drive_err++;
        bit_valid_i = 1'b1; bit_i = b;
        @(negedge clk); bit_valid_i = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        @(negedge clk);
        b = ~drive_low_o;
        bit_valid_i = 1'b1; bit_i = b;
        @(negedge clk); bit_valid_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);
    endtask

    task automatic wr_id(input int flip);
        for (int i = 0; i < 64; i++) wr_bit(exp_id[i] ^ (i == flip));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic [7:0]  res;
        logic        b, t, c;
        int          bad;
        exp_id = {ref_crc({SER, FAM}), SER, FAM};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!selected_o && !overdrive_o && !drive_low_o, "R1 reset state",
            {selected_o, overdrive_o, drive_low_o}, 0);
        wr_byte(8'hCC);
        chk(!selected_o, "R1 slots before bus reset ignored", selected_o, 0);

        foreach (VEC[k]) begin
            bus_rst(VEC[k][10]);
            wr_byte(VEC[k][9:2]);
            chk(selected_o == VEC[k][1] && overdrive_o == VEC[k][0], "R6/R7/R8/R10/R11 table",
                {selected_o, overdrive_o}, VEC[k][1:0]);
        end

        // R3 read identity
        bus_rst(1'b1); wr_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin rd_bit(b); got[i] = b; end
        chk(got == exp_id, "R3 identity bits", got, exp_id);
        res = 8'h00;
        for (int i = 0; i < 64; i++) begin
            logic fb = res[0] ^ got[i];
            res = {1'b0, res[7:1]} ^ (fb ? 8'h8C : 8'h00);
        end
        chk(res == 8'h00 && got[7:0] == 8'h23, "R3 crc residual and family", {res, got[7:0]}, 64'h23);
        chk(selected_o, "R3 selected after 64 slots", selected_o, 1);

        // R2 reset in the middle of a command
        bus_rst(1'b1); wr_byte(8'h33);
        for (int i = 0; i < 10; i++) rd_bit(b);
        bus_rst(1'b0);
        chk(!selected_o && !drive_low_o, "R2 abort releases line", {selected_o, drive_low_o}, 0);
        wr_byte(8'hCC);
        chk(selected_o, "R2 new command after abort", selected_o, 1);

        // R4 match success, then resume
        bus_rst(1'b1); wr_byte(8'h55); wr_id(-1);
        chk(selected_o, "R4 full match selects", selected_o, 1);
        bus_rst(1'b1); wr_byte(8'hA5);
        chk(selected_o, "R7 resume after match", selected_o, 1);

        // R4 mismatch at bit 40
        bus_rst(1'b1); wr_byte(8'h55); wr_id(40);
        chk(!selected_o && !drive_low_o, "R4 mismatch stays deselected", {selected_o, drive_low_o}, 0);
        bus_rst(1'b1); wr_byte(8'hA5);
        chk(!selected_o, "R7 match command cleared flag", selected_o, 0);

        // R5 full search
        bus_rst(1'b1); wr_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd_bit(t); rd_bit(c);
            if (t != exp_id[i] || c != !exp_id[i]) bad++;
            wr_bit(exp_id[i]);
        end
        chk(bad == 0, "R5 search true/complement slots", bad, 0);
        chk(selected_o, "R5 search completes", selected_o, 1);
        bus_rst(1'b0); wr_byte(8'hA5);
        chk(selected_o, "R7 resume after search", selected_o, 1);

        // R5 search drop-out at bit 10
        bus_rst(1'b1); wr_byte(8'hF0);
        for (int i = 0; i < 11; i++) begin
            rd_bit(t); rd_bit(c);
            wr_bit(exp_id[i] ^ (i == 10));
        end
        rd_bit(t); rd_bit(c);
        chk(t && c && !selected_o, "R5 dropped slave releases line", {t, c, selected_o}, 64'h6);

        // R9 overdrive-match success from standard speed
        bus_rst(1'b1); wr_byte(8'h69);
        chk(overdrive_o, "R9 fast mode at command byte", overdrive_o, 1);
        wr_id(-1);
        chk(selected_o && overdrive_o, "R9 match success keeps fast", {selected_o, overdrive_o}, 3);
        bus_rst(1'b0); wr_byte(8'hA5);
        chk(selected_o && overdrive_o, "R7 resume after fast match", {selected_o, overdrive_o}, 3);

        // R9 mismatch with fast mode previously off
        bus_rst(1'b1); wr_byte(8'h69); wr_id(5);
        chk(!selected_o && !overdrive_o, "R9 fall back to standard", {selected_o, overdrive_o}, 0);

        // R9 mismatch with fast mode previously on
        bus_rst(1'b1); wr_byte(8'h3C);
        bus_rst(1'b0); wr_byte(8'h69); wr_id(5);
        chk(!selected_o && overdrive_o, "R9 stays fast when already fast", {selected_o, overdrive_o}, 1);

        chk(rx_drive_err == 0, "R12 line released in receive slots", rx_drive_err, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule